// File: doc/BRIEF.md
# Sequential AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It does this by reusing a single round datapath for all ten rounds. A one-cycle start pulse captures the plaintext and the key. The controller first XORs the plaintext with the cipher key. It then runs the shared round ten times. Rounds 1 to 9 apply byte substitution, row rotation, column mixing and round-key XOR, in that order. Round 10 leaves out the column mixing.

The round is split into five register steps: substitution, row rotation, column mixing, key update and state writeback. The key expansion for the next round key advances in the same steps, so the round key for round r is ready exactly when the state of round r is XORed with it. One encryption therefore takes a fixed 52 cycles. The result appears on the ciphertext output together with a one-cycle done pulse. The result stays there until the next encryption completes.

Byte order: byte 0 of a block is bits [127:120] and byte 15 is bits [7:0]. Byte i sits in row i mod 4, column i div 4.

Top module: `aes128_seq_enc`

## Requirements
- R1: While reset is asserted and after its release, before any start, done_o is 0 and ct_o is all zeros.
- R2: For plaintext 00112233445566778899aabbccddeeff and key 000102030405060708090a0b0c0d0e0f, ct_o becomes 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: For any plaintext and key, ct_o equals AES-128 encryption under the byte order above. This covers the sequence of key-0 whitening, nine full rounds and a final round without column mixing, with row r rotated left by r bytes.
- R4: done_o rises on the 52nd rising clock edge after the edge that samples start_i high in idle, and not earlier.
- R5: done_o is high for exactly one cycle per encryption.
- R6: A start pulse while an encryption is in progress is ignored. It does not change that result or its timing, and it never yields an extra done pulse.
- R7: ct_o changes only on the edge that raises done_o. Otherwise it holds its last value.
- R8: A start sampled on the edge right after the done pulse, with start_i high during the done cycle, begins a new encryption with the same 52-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| pt_i | input | 128 | Plaintext, captured with start |
| key_i | input | 128 | Cipher key, captured with start |
| ct_o | output | 128 | Ciphertext, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due exactly 52 rising edges after the edge that samples start. The bench drives on falling edges and counts falling edges after that sampling edge. It records the first falling edge at which done_o is seen high and expects index 52, with ct_o compared in that same half-cycle. The falling edge after that must show done_o low and ct_o unchanged. Busy-time starts are injected ten cycles into a run, and a further 60-cycle window is checked for a stray done pulse. Back-to-back runs raise start during the done cycle itself.

// File: rtl/aes128_seq_enc.sv
module aes128_seq_enc (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [127:0] pt_i,
  input  logic [127:0] key_i,
  output logic [127:0] ct_o,
  output logic         done_o
);
  localparam int unsigned NR  = 10;
  localparam int unsigned NPH = 5;

  typedef enum logic [1:0] {IDLE, LOAD, RUN, FIN} fsm_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, t;
    acc = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = xt(t);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] rot_rows(input logic [127:0] v);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(r+4*c) -: 8] = v[127-8*(r+4*((c+r)%4)) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] mix(input logic [127:0] v);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = v[127-32*c -: 8];
      a1 = v[119-32*c -: 8];
      a2 = v[111-32*c -: 8];
      a3 = v[103-32*c -: 8];
      o[127-32*c -: 8] = gmul(a0, 8'h02) ^ gmul(a1, 8'h03) ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ gmul(a1, 8'h02) ^ gmul(a2, 8'h03) ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ gmul(a2, 8'h02) ^ gmul(a3, 8'h03);
      o[103-32*c -: 8] = gmul(a0, 8'h03) ^ a1 ^ a2 ^ gmul(a3, 8'h02);
    end
    return o;
  endfunction

  fsm_t         fsm;
  logic [127:0] in_pt, in_key, st, s1, s2, s3, rk;
  logic [31:0]  kt;
  logic [7:0]   rcon;
  logic [3:0]   rnd;
  logic [2:0]   ph;

  logic [127:0] sub_w;
  logic [31:0]  rot_w, ksub_w;
  logic [31:0]  n0, n1, n2, n3;

  genvar g;
  for (g = 0; g < 16; g++) begin : g_sub
    assign sub_w[8*g +: 8] = sbox(st[8*g +: 8]);
  end

  assign rot_w = {rk[23:0], rk[31:24]};
  for (g = 0; g < 4; g++) begin : g_ksub
    assign ksub_w[8*g +: 8] = sbox(rot_w[8*g +: 8]);
  end

  assign n0 = rk[127:96] ^ kt;
  assign n1 = rk[95:64] ^ n0;
  assign n2 = rk[63:32] ^ n1;
  assign n3 = rk[31:0] ^ n2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm    <= IDLE;
      done_o <= 1'b0;
      ct_o   <= '0;
      in_pt  <= '0;
      in_key <= '0;
      st     <= '0;
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      rk     <= '0;
      kt     <= '0;
      rcon   <= 8'h01;
      rnd    <= 4'd0;
      ph     <= 3'd0;
    end else begin
      done_o <= 1'b0;
      case (fsm)
        IDLE: if (start_i) begin
          in_pt  <= pt_i;
          in_key <= key_i;
          fsm    <= LOAD;
        end
        LOAD: begin
          st   <= in_pt ^ in_key;
          rk   <= in_key;
          rcon <= 8'h01;
          rnd  <= 4'd1;
          ph   <= 3'd0;
          fsm  <= RUN;
        end
        RUN: begin
          case (ph)
            3'd0: begin
              s1 <= sub_w;
              kt <= ksub_w ^ {rcon, 24'h0};
            end
            3'd1: s2 <= rot_rows(s1);
            3'd2: s3 <= (rnd == 4'(NR)) ? s2 : mix(s2);
            3'd3: begin
              rk   <= {n0, n1, n2, n3};
              rcon <= xt(rcon);
            end
            default: begin
              st <= s3 ^ rk;
              if (rnd == 4'(NR)) fsm <= FIN;
              else rnd <= rnd + 4'd1;
            end
          endcase
          ph <= (ph == 3'(NPH - 1)) ? 3'd0 : ph + 3'd1;
        end
        default: begin
          ct_o   <= st;
          done_o <= 1'b1;
          fsm    <= IDLE;
        end
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);

  // R7
  ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(ct_o));

  // R4
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(fsm) == FIN);

  // R4
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == RUN) |-> (rnd >= 4'd1 && rnd <= 4'(NR) && ph <= 3'(NPH - 1)));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == RUN) |=> (fsm == RUN || fsm == FIN));

  // R8
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == IDLE && start_i) |=> (fsm == LOAD));
endmodule

// File: tb/aes128_seq_enc_tb.sv
module aes128_seq_enc_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         start;
  logic [127:0] pt, key;
  logic [127:0] ct;
  logic         done;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] sb [256];

  aes128_seq_enc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .pt_i(pt), .key_i(key), .ct_o(ct), .done_o(done)
  );

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = dbl(x);
    end
    return r;
  endfunction

  function automatic logic [127:0] aes_ref(input logic [127:0] p, input logic [127:0] k_in);
    logic [7:0] s [16];
    logic [7:0] k [16];
    logic [7:0] t [16];
    logic [7:0] w [4];
    logic [7:0] rc;
    logic [127:0] o;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      k[i] = k_in[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) t[q+4*c] = s[q+4*((c+q)%4)];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          for (int q = 0; q < 4; q++)
            s[q+4*c] = dbl(t[q+4*c]) ^ dbl(t[(q+1)%4+4*c]) ^ t[(q+1)%4+4*c]
                       ^ t[(q+2)%4+4*c] ^ t[(q+3)%4+4*c];
        end else begin
          for (int q = 0; q < 4; q++) s[q+4*c] = t[q+4*c];
        end
      end
      w[0] = sb[k[13]] ^ rc;
      w[1] = sb[k[14]];
      w[2] = sb[k[15]];
      w[3] = sb[k[12]];
      for (int j = 0; j < 4; j++) k[j] ^= w[j];
      for (int j = 4; j < 16; j++) k[j] ^= k[j-4];
      rc = dbl(rc);
      for (int i = 0; i < 16; i++) s[i] ^= k[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Entered at a falling edge; leaves at the falling edge inside the done cycle.
  task automatic enc(input logic [127:0] p, input logic [127:0] k, input logic [127:0] exp,
                     input string tag, input bit inj);
    int lat;
    lat = 0;
    start = 1'b1;
    pt = p;
    key = k;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 60 && lat == 0; n++) begin
      @(negedge clk);
      start = inj && (n == 10);
      if (inj && n == 10) begin
        pt = ~p;
        key = ~k;
      end
      if (done) lat = n;
    end
    start = 1'b0;
    chk(lat == 52, inj ? "R6 latency with busy start" : "R4 latency", 128'(lat), 128'd52);
    chk(ct === exp, tag, ct, exp);
  endtask

  task automatic after_done(input logic [127:0] exp);
    @(negedge clk);
    chk(done === 1'b0, "R5 done pulse width", 128'(done), 128'd0);
    chk(ct === exp, "R7 result held", ct, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] p, k, e, p2, k2, e2;
    int dones;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv, y;
      iv = 8'h00;
      for (int z = 1; z < 256; z++)
        if (fmul(8'(x), 8'(z)) == 8'h01) iv = 8'(z);
      for (int b = 0; b < 8; b++)
        y[b] = iv[b] ^ iv[(b+4)%8] ^ iv[(b+5)%8] ^ iv[(b+6)%8] ^ iv[(b+7)%8] ^ ((8'h63 >> b) & 1);
      sb[x] = y;
    end

    rst_n = 1'b0;
    start = 1'b0;
    pt = '0;
    key = '0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done in reset", 128'(done), 128'd0);
    chk(ct === '0, "R1 ct in reset", ct, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done === 1'b0 && ct === '0, "R1 after reset", ct, '0);

    e = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, e, "R2 known vector", 1'b0);
    after_done(e);
    repeat (5) @(negedge clk);
    chk(ct === e, "R7 held while idle", ct, e);

    e = 128'h3925841d02dc09fbdc118597196a0b32;
    enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, e, "R3 second vector", 1'b0);
    after_done(e);

    e = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    enc('0, '0, e, "R3 all-zero vector", 1'b0);
    chk(aes_ref('0, '0) === e, "R3 bench model", aes_ref('0, '0), e);
    after_done(e);

    for (int v = 0; v < 16; v++) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      if (v == 0) p = '1;
      if (v == 1) k = '1;
      e = aes_ref(p, k);
      enc(p, k, e, "R3 sweep", 1'b0);
      after_done(e);
    end

    p = {$urandom, $urandom, $urandom, $urandom};
    k = {$urandom, $urandom, $urandom, $urandom};
    e = aes_ref(p, k);
    @(negedge clk);
    enc(p, k, e, "R6 result with busy start", 1'b1);
    after_done(e);
    dones = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 0, "R6 no extra done", 128'(dones), 128'd0);
    chk(ct === e, "R7 held after ignored start", ct, e);

    p2 = 128'h00112233445566778899aabbccddeeff;
    k2 = 128'h000102030405060708090a0b0c0d0e0f;
    e2 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    for (int v = 0; v < 4; v++) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      e = aes_ref(p, k);
      enc(p, k, e, "R8 back-to-back first", 1'b0);
      enc(p2, k2, e2, "R8 back-to-back second", 1'b0);
      after_done(e2);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule